// File: doc/BRIEF.md
# Memory-Backed Bus Read Responder with Byte-Lane Steering

This block is a read-only slave on a synchronous 32-bit bus. It samples the transfer-start strobe together with the address, the direction and a two-bit size code. It responds only to reads that fall inside its address window. The matching word comes from a local word array. Only the byte lanes that the transfer size and the two low address bits select are driven. The other lanes are forced to zero. The transfer ends with a single-cycle acknowledge. The data-enable output is high only in that cycle, which models the bus being released to high impedance straight after.

A line read (size code 11) is handled in one of two ways, chosen by a parameter. In the inhibit variant, the slave returns the addressed long word and raises burst-inhibit together with the acknowledge. The master then fetches the rest of the line with three ordinary long-word reads. In the burst variant, the slave returns all four long words of the aligned line. It starts at the addressed word and wraps within the line.

The number of wait states before each acknowledge is a parameter. A misaligned word or long-word access returns undefined data and raises an error flag during its acknowledge, for test use.

Top module: `bus_rd_slave`

## Requirements
- R1: A transfer is accepted only when `ts` is high, `rd` is high, `addr[31:WIN_BITS]` equals `BASE_ADDR[31:WIN_BITS]`, and the slave is idle.
- R2: Size codes are 00 long, 01 byte, 10 word and 11 line. Lane mapping is big-endian. A byte at offset o (`addr[1:0]`) appears on bits [31-8o -: 8]. A word with `addr[1]`=0 appears on bits 31..16, and with `addr[1]`=1 on bits 15..0. A long word uses all 32 bits. Lanes that are not selected read as zero.
- R3: Each transfer raises `ta` for exactly one cycle. Counting the cycle in which `ts` is sampled as cycle 0, the first `ta` falls in cycle WAIT_STATES+2.
- R4: `data_oe` is high exactly in the cycles in which `ta` is high. Whenever `data_oe` is low, `data_out` is zero.
- R5: With INHIBIT_BURST=1, a line read gets one acknowledge carrying the long word at the address, with `tbi` high in the same cycle. The following long-word reads are served normally.
- R6: With INHIBIT_BURST=0, a line read gets four acknowledges spaced WAIT_STATES+2 cycles apart. They carry the words with index {idx[3:2], idx[1:0]+j} for j=0..3, and `tbi` stays low.
- R7: Reads outside the window and all writes (`rd` low) never produce `ta` or `data_oe`.
- R8: Array word i holds the bytes, from high to low: (7i+17) mod 256, (i XOR C3h) mod 256, (i+40h) mod 256, and (NOT i) mod 256.
- R9: `err` is high with `ta` for a word with `addr[0]`=1, or for a long or line read with `addr[1:0]`≠0. Otherwise it stays low.
- R10: After reset, `ta`, `data_oe`, `tbi` and `err` are low and `data_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ts | input | 1 | Transfer-start strobe, one cycle |
| rd | input | 1 | High for a read transfer |
| addr | input | 32 | Byte address of the transfer |
| siz | input | 2 | Size code: 00 long, 01 byte, 10 word, 11 line |
| data_out | output | 32 | Read data, steered to the selected lanes |
| data_oe | output | 1 | High while the slave drives the data bus |
| ta | output | 1 | Transfer acknowledge, one cycle per transfer |
| tbi | output | 1 | Burst inhibit, given with the acknowledge of a line read |
| err | output | 1 | Misaligned-access flag, given with the acknowledge |

## Verification
The bench sweeps every byte address of the window with byte, word and long sizes, and every long-word address with line reads. Two instances are used, one per line-read variant, each with a different wait-state count. A wrong lane mask would leave stray bytes on idle lanes or put bytes on the wrong lanes, and the arithmetic data check catches both. An off-by-one in the wait counter, or a stale memory read after a burst beat, would move `ta` or repeat the previous word. The wrap test at the line end catches an address increment that carries out of the line. Window-edge addresses and writes cover a decoder that responds too widely.

// File: rtl/bus_rd_slave_pkg.sv
package bus_rd_slave_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } resp_state_e;

  // Initial content of array word i, one byte per lane.
  function automatic logic [31:0] fill_word(input int unsigned i);
    logic [7:0] v;
    v = i[7:0];
    return {v * 8'd7 + 8'd17, v ^ 8'hC3, v + 8'h40, ~v};
  endfunction

endpackage

// File: rtl/bus_rd_slave_decode.sv
module bus_rd_slave_decode
  import bus_rd_slave_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          WIN_BITS  = 6
) (
  input  logic [31:0] addr,
  input  xfer_size_e  size,
  output logic        hit,
  output logic        misaligned
);

  assign hit = (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_WORD: misaligned = addr[0];
      default: misaligned = |addr[1:0];
    endcase
  end

endmodule

// File: rtl/bus_rd_slave_rom.sv
module bus_rd_slave_rom
  import bus_rd_slave_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] raddr,
  output logic [31:0]      rdata
);

  logic [31:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_word(i);
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bus_rd_slave_lanes.sv
module bus_rd_slave_lanes
  import bus_rd_slave_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  offs,
  input  xfer_size_e  size,
  output logic [3:0]  lane_en,
  output logic [31:0] steered
);

  // lane_en[3] is bits 31..24 (offset 0), lane_en[0] is bits 7..0.
  always_comb begin
    unique case (size)
      SZ_BYTE: lane_en = 4'b1000 >> offs;
      SZ_WORD: lane_en = offs[1] ? 4'b0011 : 4'b1100;
      default: lane_en = 4'b1111;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign steered[8*g +: 8] = lane_en[g] ? word[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/bus_rd_slave_ctrl.sv
module bus_rd_slave_ctrl
  import bus_rd_slave_pkg::*;
#(
  parameter int WAIT_STATES   = 1,
  parameter int IDX_W         = 4,
  parameter bit INHIBIT_BURST = 1'b1,
  localparam int CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts,
  input  logic             rd,
  input  logic             hit,
  input  logic             misaligned,
  input  xfer_size_e       size_in,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [1:0]       bus_offs,
  input  logic [31:0]      steered,
  output logic [IDX_W-1:0] ram_idx,
  output logic [1:0]       offs_q,
  output xfer_size_e       size_q,
  output logic             ta,
  output logic             data_oe,
  output logic [31:0]      data_out,
  output logic             tbi,
  output logic             err
);

  resp_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beats_left_q;
  logic [1:0]       first_beats;
  logic [IDX_W-1:0] beat_idx_q;
  logic [IDX_W-1:0] next_idx;
  logic             line_q;
  logic             err_pend_q;
  logic             accept;

  assign accept   = (st_q == ST_IDLE) && ts && rd && hit;
  assign next_idx = {beat_idx_q[IDX_W-1:2], beat_idx_q[1:0] + 2'd1};

  // The parameter picks whether a line read becomes one beat or four.
  if (INHIBIT_BURST) begin : g_inhibit
    assign first_beats = 2'd0;
  end else begin : g_burst
    assign first_beats = (size_in == SZ_LINE) ? 2'd3 : 2'd0;
  end

  // The array address leads the beat by one cycle so its registered read lines up.
  always_comb begin
    if (st_q == ST_IDLE)                              ram_idx = bus_idx;
    else if (st_q == ST_ACK && beats_left_q != 2'd0)  ram_idx = next_idx;
    else                                              ram_idx = beat_idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      beats_left_q <= 2'd0;
      beat_idx_q   <= '0;
      offs_q       <= 2'd0;
      size_q       <= SZ_LONG;
      line_q       <= 1'b0;
      err_pend_q   <= 1'b0;
      ta           <= 1'b0;
      data_oe      <= 1'b0;
      data_out     <= '0;
      tbi          <= 1'b0;
      err          <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q         <= ST_WAIT;
            cnt_q        <= CNT_W'(WAIT_STATES);
            beats_left_q <= first_beats;
            beat_idx_q   <= bus_idx;
            offs_q       <= bus_offs;
            size_q       <= size_in;
            line_q       <= (size_in == SZ_LINE);
            err_pend_q   <= misaligned;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            st_q     <= ST_ACK;
            ta       <= 1'b1;
            data_oe  <= 1'b1;
            data_out <= steered;
            tbi      <= line_q && INHIBIT_BURST;
            err      <= err_pend_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACK: begin
          ta       <= 1'b0;
          data_oe  <= 1'b0;
          data_out <= '0;
          tbi      <= 1'b0;
          err      <= 1'b0;
          if (beats_left_q != 2'd0) begin
            st_q         <= ST_WAIT;
            cnt_q        <= CNT_W'(WAIT_STATES);
            beats_left_q <= beats_left_q - 2'd1;
            beat_idx_q   <= next_idx;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_ta_single_r3: assert property (@(posedge clk) disable iff (rst)
    ta |=> !ta);

  p_release_after_ta_r4: assert property (@(posedge clk) disable iff (rst)
    ta |=> !data_oe);

  p_tbi_with_ta_r5: assert property (@(posedge clk) disable iff (rst)
    tbi |-> ta);

  p_miss_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ts && !(rd && hit)) |=> (st_q == ST_IDLE));

  p_err_with_ta_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> ta);

endmodule

// File: rtl/bus_rd_slave.sv
module bus_rd_slave
  import bus_rd_slave_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR     = 32'h0000_1000,
  parameter int          WIN_BITS      = 6,
  parameter int          WAIT_STATES   = 1,
  parameter bit          INHIBIT_BURST = 1'b1,
  localparam int         IDX_W         = WIN_BITS - 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ts,
  input  logic        rd,
  input  logic [31:0] addr,
  input  logic [1:0]  siz,
  output logic [31:0] data_out,
  output logic        data_oe,
  output logic        ta,
  output logic        tbi,
  output logic        err
);

  xfer_size_e       size_in;
  xfer_size_e       size_q;
  logic             hit;
  logic             misaligned;
  logic [IDX_W-1:0] ram_idx;
  logic [1:0]       offs_q;
  logic [31:0]      rdata;
  logic [31:0]      steered;
  logic [3:0]       lane_en;

  assign size_in = xfer_size_e'(siz);

  bus_rd_slave_decode #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_BITS  (WIN_BITS)
  ) u_decode (
    .addr       (addr),
    .size       (size_in),
    .hit        (hit),
    .misaligned (misaligned)
  );

  bus_rd_slave_rom #(
    .IDX_W (IDX_W)
  ) u_rom (
    .clk   (clk),
    .raddr (ram_idx),
    .rdata (rdata)
  );

  bus_rd_slave_lanes u_lanes (
    .word    (rdata),
    .offs    (offs_q),
    .size    (size_q),
    .lane_en (lane_en),
    .steered (steered)
  );

  bus_rd_slave_ctrl #(
    .WAIT_STATES   (WAIT_STATES),
    .IDX_W         (IDX_W),
    .INHIBIT_BURST (INHIBIT_BURST)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ts         (ts),
    .rd         (rd),
    .hit        (hit),
    .misaligned (misaligned),
    .size_in    (size_in),
    .bus_idx    (addr[WIN_BITS-1:2]),
    .bus_offs   (addr[1:0]),
    .steered    (steered),
    .ram_idx    (ram_idx),
    .offs_q     (offs_q),
    .size_q     (size_q),
    .ta         (ta),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .tbi        (tbi),
    .err        (err)
  );

  p_lane_count_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ta) |-> ($past(lane_en) inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                          4'b0011, 4'b1100, 4'b1111}));

endmodule

// File: tb/bus_rd_slave_tb_top.sv
`timescale 1ns/1ps
module bus_rd_slave_tb_top;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int          WB   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ts  = 1'b0;
  logic        rd  = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  siz  = 2'b00;

  logic [31:0] a_data, b_data;
  logic        a_oe, a_ta, a_tbi, a_err;
  logic        b_oe, b_ta, b_tbi, b_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bus_rd_slave #(.BASE_ADDR(BASE), .WIN_BITS(WB), .WAIT_STATES(1), .INHIBIT_BURST(1'b1)) dut_i (
    .clk(clk), .rst(rst), .ts(ts), .rd(rd), .addr(addr), .siz(siz),
    .data_out(a_data), .data_oe(a_oe), .ta(a_ta), .tbi(a_tbi), .err(a_err));

  bus_rd_slave #(.BASE_ADDR(BASE), .WIN_BITS(WB), .WAIT_STATES(0), .INHIBIT_BURST(1'b0)) dut_b_i (
    .clk(clk), .rst(rst), .ts(ts), .rd(rd), .addr(addr), .siz(siz),
    .data_out(b_data), .data_oe(b_oe), .ta(b_ta), .tbi(b_tbi), .err(b_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [7:0] v;
    v = i[7:0];
    return {v * 8'd7 + 8'd17, v ^ 8'hC3, v + 8'h40, ~v};
  endfunction

  function automatic logic [31:0] expect_data(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] w;
    w = pat(int'(a[WB-1:2]));
    case (s)
      2'b01:   return w & (32'hFF00_0000 >> (8 * a[1:0]));
      2'b10:   return a[1] ? (w & 32'h0000_FFFF) : (w & 32'hFFFF_0000);
      default: return w;
    endcase
  endfunction

  task automatic run_xfer(input logic [31:0] a, input logic [1:0] s, input bit r);
    int          a_n, a_k, a_bad, b_n, b_bad;
    logic [31:0] a_d;
    logic        a_t, a_e;
    int          b_k [4];
    logic [31:0] b_d [4];
    logic        b_t [4];
    logic        b_e [4];
    bit          hit, mis;
    a_n = 0; a_k = 0; a_bad = 0; b_n = 0; b_bad = 0;
    a_d = '0; a_t = 1'b0; a_e = 1'b0;
    for (int j = 0; j < 4; j++) begin b_k[j] = 0; b_d[j] = '0; b_t[j] = 1'b0; b_e[j] = 1'b0; end
    @(negedge clk);
    addr = a; siz = s; rd = r; ts = 1'b1;
    @(negedge clk);
    ts = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      if (a_ta) begin a_n++; a_k = k; a_d = a_data; a_t = a_tbi; a_e = a_err; end
      if (a_oe !== a_ta) a_bad++;
      if (!a_oe && a_data != 0) a_bad++;
      if (b_ta) begin
        if (b_n < 4) begin b_k[b_n] = k; b_d[b_n] = b_data; b_t[b_n] = b_tbi; b_e[b_n] = b_err; end
        b_n++;
      end
      if (b_oe !== b_ta) b_bad++;
      if (!b_oe && b_data != 0) b_bad++;
      @(negedge clk);
    end
    chk(a_bad == 0, "R4 enable/idle-data (inhibit unit)", a_bad, 0);
    chk(b_bad == 0, "R4 enable/idle-data (burst unit)", b_bad, 0);
    hit = r && (a[31:WB] == BASE[31:WB]);
    if (!hit) begin
      chk(a_n == 0, "R7 no response (inhibit unit)", a_n, 0);
      chk(b_n == 0, "R7 no response (burst unit)", b_n, 0);
      return;
    end
    mis = (s == 2'b10) ? a[0] : ((s == 2'b01) ? 1'b0 : (a[1:0] != 2'b00));
    // Inhibit unit, WAIT_STATES=1: one acknowledge in cycle 3.
    chk(a_n == 1, "R3 single acknowledge", a_n, 1);
    chk(a_k == 3, "R3 acknowledge cycle", a_k, 3);
    if (!mis) chk(a_d == expect_data(a, s), (s == 2'b11) ? "R5 line word" : "R2 R8 lane data", a_d, expect_data(a, s));
    chk(a_t == (s == 2'b11), "R5 burst-inhibit", a_t, (s == 2'b11));
    chk(a_e == mis, "R9 error flag", a_e, mis);
    // Burst unit, WAIT_STATES=0.
    if (s != 2'b11) begin
      chk(b_n == 1 && b_k[0] == 2, "R3 acknowledge cycle (burst unit)", b_k[0], 2);
      if (!mis) chk(b_d[0] == expect_data(a, s), "R2 lane data (burst unit)", b_d[0], expect_data(a, s));
      chk(b_e[0] == mis, "R9 error flag (burst unit)", b_e[0], mis);
    end else begin
      chk(b_n == 4, "R6 beat count", b_n, 4);
      for (int j = 0; j < 4; j++) begin
        logic [1:0]  lo;
        logic [31:0] ew;
        lo = a[3:2] + 2'(j);
        ew = pat(int'({a[5:4], lo}));
        chk(b_k[j] == 2 + 2 * j, "R6 beat spacing", b_k[j], 2 + 2 * j);
        if (!mis) chk(b_d[j] == ew, "R6 wrapped beat data", b_d[j], ew);
        chk(b_t[j] == 1'b0, "R6 no burst-inhibit", b_t[j], 0);
        chk(b_e[j] == mis, "R9 error flag on beat", b_e[j], mis);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: quiet outputs after reset.
    chk(!a_ta && !a_oe && !a_tbi && !a_err, "R10 reset controls", {a_ta, a_oe, a_tbi, a_err}, 0);
    chk(a_data == 0 && b_data == 0, "R10 reset data", a_data | b_data, 0);
    chk(!b_ta && !b_oe && !b_tbi && !b_err, "R10 reset controls (burst unit)", {b_ta, b_oe, b_tbi, b_err}, 0);

    // R1 R2 R8 R9: every byte address in the window with byte, word and long sizes.
    for (int o = 0; o < (1 << WB); o++) begin
      run_xfer(BASE + 32'(o), 2'b01, 1'b1);
      run_xfer(BASE + 32'(o), 2'b10, 1'b1);
      run_xfer(BASE + 32'(o), 2'b00, 1'b1);
    end

    // R5 R6: line read at each word, then the three follow-up long reads.
    for (int w = 0; w < (1 << (WB - 2)); w++) begin
      logic [31:0] la;
      la = BASE + 32'(4 * w);
      run_xfer(la, 2'b11, 1'b1);
      for (int j = 1; j < 4; j++)
        run_xfer({la[31:4], la[3:2] + 2'(j), 2'b00}, 2'b00, 1'b1);
    end
    // R9: misaligned line read.
    run_xfer(BASE + 32'd2, 2'b11, 1'b1);

    // R7: window edges outside and writes inside.
    run_xfer(BASE - 32'd1, 2'b01, 1'b1);
    run_xfer(BASE - 32'd4, 2'b00, 1'b1);
    run_xfer(BASE + 32'(1 << WB), 2'b00, 1'b1);
    run_xfer(32'h8000_1000, 2'b11, 1'b1);
    run_xfer(BASE, 2'b00, 1'b0);
    run_xfer(BASE + 32'd8, 2'b11, 1'b0);
    // R1: slave still answers after the ignored cycles.
    run_xfer(BASE + 32'h3C, 2'b00, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule